// File: doc/BRIEF.md
# Calibration Pulse Period Meter

This block sits on the host side of a low-power interval timer. The timer emits one calibration pulse whose high time equals one period of its slow internal oscillator. The meter counts the length of that pulse in cycles of a fast, accurate reference clock. It then multiplies the count by the factor that belongs to the selected delay code. The product is the true length of the timer's delay period in reference ticks, corrected for the drift of the slow oscillator.

Measurement runs only when software requests it, for example after a temperature change. A start request arms the meter. The meter then waits for a complete pulse, counts it, and publishes both the raw base period and the scaled delay together with a sticky done flag. If a pulse is too long for the counter, the meter raises an overflow flag and publishes no result.

Top module: `calpulse_meter`

## Requirements
- R1: After reset, `meas_done` and `meas_ovf` are 0, and `base_ticks` and `delay_ticks` are 0.
- R2: The pulse input passes through a synchronizer of `SYNC_STAGES` flops. `base_ticks` equals the number of reference clock edges at which the synchronized pulse was high, counted from its first high sample to the following low sample. A pulse held high for W clock cycles therefore gives `base_ticks` = W, with a resolution of one tick.
- R3: `delay_ticks` = `base_ticks` × N, where N depends on the 3-bit select code: 000→64, 001→128, 010→256, 011→512, 101→1024, 110→2048, 111→4096.
- R4: Select code 100 uses N = 640, formed as (width<<9)+(width<<7).
- R5: If a start request arrives while the synchronized pulse is already high, that partial pulse is skipped. The next complete pulse is measured.
- R6: A pulse still high after 2^CNT_W−1 counted samples sets `meas_ovf`, and `meas_done` stays 0. A width of exactly 2^CNT_W−1 is measured normally. `meas_done` and `meas_ovf` are never both 1.
- R7: `meas_done`, `base_ticks` and `delay_ticks` hold their values until the next accepted start. An accepted start clears `meas_done` and `meas_ovf` on the following clock edge.
- R8: The select code is captured when the start is accepted. Changes to `dly_sel` after that do not affect the result.
- R9: A start request while a measurement is in progress is ignored, and the pulse in progress is still measured in full.
- R10: Pulses that arrive with no start request leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tcal_in | input | 1 | Calibration pulse, asynchronous to `clk` |
| dly_sel | input | 3 | Delay select code that chooses N |
| start | input | 1 | Measurement request, one cycle high |
| base_ticks | output | CNT_W | Measured pulse width in reference ticks |
| delay_ticks | output | CNT_W+12 | Base width scaled by N |
| meas_done | output | 1 | Result valid (sticky until next start) |
| meas_ovf | output | 1 | Pulse exceeded the counter range (sticky until next start) |

## Verification
The assertions are checked on every cycle. They cover the following: `delay_ticks` agrees with an ordinary multiplication of `base_ticks` by the factor for the captured code at the moment a result appears; done and overflow are never raised together; a published result stays stable until the next start; and an accepted start clears both flags. The following can only be shown by the bench scenarios, because each depends on the shape of the stimulus over many cycles: the exact width count, skipping a pulse that was already high, the boundary between the largest valid width and overflow, ignoring a second start, capturing the select code, and ignoring pulses that arrive with no request.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int SEL_W     = 3;
  localparam int MAX_SHIFT = 12;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAIT_HI,
    ST_COUNT
  } cpm_state_e;

  // Scale factor per select code, used by the checker as an independent reference
  function automatic int unsigned cpm_factor(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 64;
      3'd1:    return 128;
      3'd2:    return 256;
      3'd3:    return 512;
      3'd4:    return 640;
      3'd5:    return 1024;
      3'd6:    return 2048;
      default: return 4096;
    endcase
  endfunction
endpackage

// File: rtl/cpm_sync.sv
module cpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sh[i] <= 1'b0;
        else     sh[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sh[i] <= 1'b0;
        else     sh[i] <= sh[i-1];
      end
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cpm_width_ctr.sv
module cpm_width_ctr
  import cpm_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tcal_s,
  input  logic             start,
  input  logic [SEL_W-1:0] dly_sel,
  output logic             start_acc,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas_width,
  output logic [SEL_W-1:0] meas_sel,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  cpm_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign start_acc  = start && (state == ST_IDLE);
  assign meas_vld   = (state == ST_COUNT) && !tcal_s;
  assign meas_width = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      meas_sel <= '0;
      overflow <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            overflow <= 1'b0;
            meas_sel <= dly_sel;
            state    <= ST_ARM;
          end
        end
        ST_ARM: begin
          // skip any pulse already in progress
          if (!tcal_s) state <= ST_WAIT_HI;
        end
        ST_WAIT_HI: begin
          if (tcal_s) begin
            cnt   <= CNT_W'(1);
            state <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (tcal_s) begin
            if (cnt == CNT_MAX) begin
              overflow <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpm_scaler.sv
module cpm_scaler
  import cpm_pkg::*;
#(
  parameter int CNT_W = 24,
  localparam int DLY_W = CNT_W + MAX_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             vld,
  input  logic [CNT_W-1:0] width,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] base_q,
  output logic [DLY_W-1:0] delay_q,
  output logic             done_q
);
  logic [DLY_W-1:0] w_ext;
  logic [DLY_W-1:0] scaled;

  assign w_ext = DLY_W'(width);

  always_comb begin
    case (sel)
      3'd0:    scaled = w_ext << 6;
      3'd1:    scaled = w_ext << 7;
      3'd2:    scaled = w_ext << 8;
      3'd3:    scaled = w_ext << 9;
      3'd4:    scaled = (w_ext << 9) + (w_ext << 7);
      3'd5:    scaled = w_ext << 10;
      3'd6:    scaled = w_ext << 11;
      default: scaled = w_ext << 12;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      delay_q <= '0;
      done_q  <= 1'b0;
    end else if (clr) begin
      done_q <= 1'b0;
    end else if (vld) begin
      base_q  <= width;
      delay_q <= scaled;
      done_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/calpulse_meter.sv
module calpulse_meter
  import cpm_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2,
  localparam int DLY_W      = CNT_W + MAX_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tcal_in,
  input  logic [2:0]       dly_sel,
  input  logic             start,
  output logic [CNT_W-1:0] base_ticks,
  output logic [DLY_W-1:0] delay_ticks,
  output logic             meas_done,
  output logic             meas_ovf
);
  logic             tcal_s;
  logic             start_acc;
  logic             meas_vld;
  logic [CNT_W-1:0] meas_width;
  logic [SEL_W-1:0] meas_sel;

  cpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (tcal_in),
    .q   (tcal_s)
  );

  cpm_width_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .tcal_s     (tcal_s),
    .start      (start),
    .dly_sel    (dly_sel),
    .start_acc  (start_acc),
    .meas_vld   (meas_vld),
    .meas_width (meas_width),
    .meas_sel   (meas_sel),
    .overflow   (meas_ovf)
  );

  cpm_scaler #(.CNT_W(CNT_W)) u_scale (
    .clk     (clk),
    .rst     (rst),
    .clr     (start_acc),
    .vld     (meas_vld),
    .width   (meas_width),
    .sel     (meas_sel),
    .base_q  (base_ticks),
    .delay_q (delay_ticks),
    .done_q  (meas_done)
  );
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker
  import cpm_pkg::*;
#(
  parameter int CNT_W = 24,
  localparam int DLY_W = CNT_W + MAX_SHIFT
) (
  input logic             clk,
  input logic             rst,
  input logic             start_acc,
  input logic [SEL_W-1:0] meas_sel,
  input logic [CNT_W-1:0] base_ticks,
  input logic [DLY_W-1:0] delay_ticks,
  input logic             meas_done,
  input logic             meas_ovf
);
  assert_done_ovf_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(meas_done && meas_ovf));

  // R3 and R4: result agrees with a plain multiplication by the captured factor
  assert_delay_scale_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(meas_done) |-> delay_ticks == DLY_W'(base_ticks) * DLY_W'(cpm_factor(meas_sel)));

  assert_base_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    meas_done |-> base_ticks != '0);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (meas_done && !start_acc) |=> (meas_done && $stable(base_ticks) && $stable(delay_ticks)));

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> (!meas_done && !meas_ovf));
endmodule

bind calpulse_meter cpm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_acc   (start_acc),
  .meas_sel    (meas_sel),
  .base_ticks  (base_ticks),
  .delay_ticks (delay_ticks),
  .meas_done   (meas_done),
  .meas_ovf    (meas_ovf)
);

// File: tb/calpulse_meter_bench.sv
module calpulse_meter_bench;
  localparam int CNT_W = 10;
  localparam int DLY_W = CNT_W + 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tcal_in = 1'b0;
  logic [2:0]       dly_sel = 3'd0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] base_ticks;
  logic [DLY_W-1:0] delay_ticks;
  logic             meas_done;
  logic             meas_ovf;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  calpulse_meter #(.CNT_W(CNT_W)) u_calpulse_meter (
    .clk(clk), .rst(rst), .tcal_in(tcal_in), .dly_sel(dly_sel), .start(start),
    .base_ticks(base_ticks), .delay_ticks(delay_ticks),
    .meas_done(meas_done), .meas_ovf(meas_ovf)
  );

  function automatic longint exp_n(input logic [2:0] s);
    case (s)
      3'd0: return 64;   3'd1: return 128;  3'd2: return 256;  3'd3: return 512;
      3'd4: return 640;  3'd5: return 1024; 3'd6: return 2048; default: return 4096;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start(input logic [2:0] s);
    @(negedge clk);
    dly_sel = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse(input int w);
    @(negedge clk);
    tcal_in = 1'b1;
    idle(w);
    tcal_in = 1'b0;
  endtask

  task automatic wait_result();
    for (int i = 0; i < 40; i++) begin
      if (meas_done || meas_ovf) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(meas_done == 1'b0, "R1 done", meas_done, 0);
    check(meas_ovf == 1'b0, "R1 ovf", meas_ovf, 0);
    check(base_ticks == '0, "R1 base", base_ticks, 0);
    check(delay_ticks == '0, "R1 delay", delay_ticks, 0);
  endtask

  task automatic t_all_codes();
    for (int s = 0; s < 8; s++) begin
      int w;
      w = 3 + s * 7;
      do_start(3'(s));
      idle(4);
      pulse(w);
      wait_result();
      check(meas_done == 1'b1, "R2 done", meas_done, 1);
      check(base_ticks == CNT_W'(w), "R2 width", base_ticks, w);
      if (s == 4)
        check(delay_ticks == DLY_W'(longint'(w) * 640), "R4 factor 640", delay_ticks, w * 640);
      else
        check(delay_ticks == DLY_W'(longint'(w) * exp_n(3'(s))), "R3 factor", delay_ticks,
              longint'(w) * exp_n(3'(s)));
      idle(5);
    end
  endtask

  task automatic t_late_start();
    @(negedge clk);
    tcal_in = 1'b1;
    idle(6);
    do_start(3'd1);
    idle(8);
    tcal_in = 1'b0;
    idle(5);
    check(meas_done == 1'b0, "R5 partial skipped", meas_done, 0);
    pulse(11);
    wait_result();
    check(meas_done == 1'b1 && base_ticks == CNT_W'(11), "R5 next pulse", base_ticks, 11);
    idle(5);
  endtask

  task automatic t_overflow();
    do_start(3'd7);
    idle(4);
    pulse(1023);
    wait_result();
    check(meas_done == 1'b1 && meas_ovf == 1'b0, "R6 max width valid", base_ticks, 1023);
    check(base_ticks == CNT_W'(1023), "R6 max width", base_ticks, 1023);
    idle(5);
    do_start(3'd0);
    idle(4);
    pulse(1024);
    wait_result();
    check(meas_ovf == 1'b1, "R6 ovf set", meas_ovf, 1);
    check(meas_done == 1'b0, "R6 done suppressed", meas_done, 0);
    idle(5);
  endtask

  task automatic t_sticky_clear();
    do_start(3'd2);
    idle(3);
    pulse(9);
    wait_result();
    idle(30);
    check(meas_done == 1'b1 && base_ticks == CNT_W'(9), "R7 held", base_ticks, 9);
    do_start(3'd2);
    check(meas_done == 1'b0, "R7 cleared by start", meas_done, 0);
    pulse(13);
    wait_result();
    check(base_ticks == CNT_W'(13), "R7 new result", base_ticks, 13);
    idle(5);
  endtask

  task automatic t_sel_capture();
    do_start(3'd2);
    dly_sel = 3'd7;
    idle(3);
    pulse(17);
    wait_result();
    check(delay_ticks == DLY_W'(17 * 256), "R8 captured select", delay_ticks, 17 * 256);
    idle(5);
  endtask

  task automatic t_restart_ignored();
    do_start(3'd0);
    idle(3);
    @(negedge clk);
    tcal_in = 1'b1;
    idle(10);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idle(9);
    tcal_in = 1'b0;
    wait_result();
    check(meas_done == 1'b1 && base_ticks == CNT_W'(20), "R9 second start ignored", base_ticks, 20);
    idle(5);
  endtask

  task automatic t_no_start();
    logic [DLY_W-1:0] d0;
    d0 = delay_ticks;
    pulse(7);
    idle(10);
    check(meas_done == 1'b1, "R10 done kept", meas_done, 1);
    check(base_ticks == CNT_W'(20) && delay_ticks == d0, "R10 result kept", base_ticks, 20);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_all_codes();
    t_late_start();
    t_overflow();
    t_sticky_clear();
    t_sel_capture();
    t_restart_ignored();
    t_no_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule